// File: doc/BRIEF.md
# Contact Card Power Sequencer

This block is the control state machine that brings a contact smart card's supply, I/O, clock and reset up in a fixed timed order, and takes them down again in the reverse order. A host drives an active-low session command, a normal/sleep mode input and a reset request. The analog side reports card presence and three fault flags: supply overcurrent, overheat and host supply drop. The block answers with registered enables for the step-up converter, the card supply, the I/O line buffers and the card clock, plus the card reset level and an active-low fault interrupt.

All sequencing is counted in ticks of a strobe that pulses once per half of the sequencing unit T, which is the internal oscillator divided by 64. A half-tick counter restarts whenever activation or deactivation is entered. A fault during a session runs the same take-down schedule and then parks the block in a fault state. A separate slow strobe, one pulse per cycle of the low-power output clock, times the wake-up from sleep.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, every enable and the card reset output are low and the interrupt is high. The block stays powered off, and will not activate, for as long as the supply-drop flag is high.
- R2: From idle, with mode high and no fault flag set, a low session command starts activation. The converter enable rises at the next clock edge. A mode rise while the command is already low starts activation in the same way.
- R3: Half-ticks are counted from the activation entry edge. The card supply enables on the edge that registers the 3rd half-tick, the I/O lines on the 8th, and the card reset path on the 14th, which completes activation. An enable is never on unless the enable before it in this order is on.
- R4: After the I/O lines are on and before the reset path is enabled, a high reset request turns the card clock on at the next edge. A request before the I/O lines are on has no effect. Once the reset path is enabled, the request never changes the clock.
- R5: Once the reset path is enabled, the card reset output is the inverse of the reset request, registered one edge later. At all other times it is low.
- R6: Deactivation starts when the session command goes high during activation or active operation. On the entry edge the card reset drops. The clock stops at the 1st half-tick, the I/O lines at the 2nd, the card supply at the 3rd, and the converter at the 10th. The block then returns to idle and accepts a new session.
- R7: A fault flag during activation or active operation (overcurrent, overheat, card absent, or supply drop) starts the same deactivation on the same edge. The interrupt goes low on that edge for every cause except a supply drop that arrives on its own.
- R8: A fault that arrives while deactivation is already running does not restart the schedule. It raises the interrupt if its cause calls for it, and the sequence ends in the fault state.
- R9: In the fault state no activation occurs. The block leaves for idle, releasing the interrupt on that edge, only when the session command is high and every fault flag is clear. In idle, a set fault flag also blocks activation.
- R10: While mode is low, no activation occurs. Mode going low during activation or active operation runs the normal deactivation and then enters low-power.
- R11: Leaving low-power needs WAKE_CYCLES (default 96) consecutive slow-clock pulses with mode high. The block is idle on the edge of the last pulse and can activate on the following edge. Mode going low again restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle strobe per half sequencing unit |
| slow_tick_i | input | 1 | One-cycle strobe per low-power output clock cycle |
| cmd_n_i | input | 1 | Session command, active low |
| mode_i | input | 1 | 1 = normal operation, 0 = sleep |
| rst_req_i | input | 1 | Host card reset request |
| card_present_i | input | 1 | 1 = card inserted |
| ovc_i | input | 1 | Card supply overcurrent flag |
| ovt_i | input | 1 | Overheat flag |
| sup_drop_i | input | 1 | Host supply below threshold |
| pump_en_o | output | 1 | Step-up converter enable |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | I/O line buffer enable |
| clk_en_o | output | 1 | Card clock enable |
| rst_o | output | 1 | Card reset level (low = card held in reset) |
| irq_n_o | output | 1 | Fault interrupt, active low |

## Verification
Two requests to take the card down can land on the same clock edge. One case is a session command release together with a card-removal flag in active operation. The other is a fault flag that arrives partway through a deactivation already under way. The bench provokes both by changing the two inputs in the same cycle, or by raising an overheat flag after the fourth half-tick of a command-driven take-down. It judges the result by three things: that the converter still drops exactly at the 10th half-tick counted from the first request, that the interrupt falls on the fault's edge, and that the block ends in the fault state, where it must release the interrupt before it will start a new session.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_ACT   = 3'd3,
    ST_ON    = 3'd4,
    ST_DEACT = 3'd5,
    ST_FAULT = 3'd6
  } seq_state_e;
endpackage

// File: rtl/card_seq_timer.sv
module card_seq_timer #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [WIDTH-1:0] step_o
);
  logic [WIDTH-1:0] cnt_q;
  logic             sat;

  assign sat    = &cnt_q;
  // count value after this edge if not cleared
  assign step_o = (tick_i && !sat) ? cnt_q + WIDTH'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= step_o;
  end

  p_cnt_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat && !clr_i) |=> sat);
endmodule

// File: rtl/card_seq_fault.sv
module card_seq_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovc_i,
  input  logic ovt_i,
  input  logic present_i,
  input  logic sup_drop_i,
  input  logic raise_i,
  input  logic clear_i,
  output logic any_o,
  output logic irq_n_o
);
  logic irq_cause;

  assign irq_cause = ovc_i | ovt_i | ~present_i;
  assign any_o     = irq_cause | sup_drop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     irq_n_o <= 1'b1;
    else if (raise_i && irq_cause)   irq_n_o <= 1'b0;
    else if (clear_i)                irq_n_o <= 1'b1;
  end

  // supply drop alone never pulls the interrupt
  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_n_o) |-> $past(ovc_i || ovt_i || !present_i));
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_seq_pkg::*;
#(
  parameter int ACT_VCC_HT  = 3,
  parameter int ACT_IO_HT   = 8,
  parameter int ACT_RST_HT  = 14,
  parameter int DEA_CLK_HT  = 1,
  parameter int DEA_IO_HT   = 2,
  parameter int DEA_VCC_HT  = 3,
  parameter int DEA_PUMP_HT = 10,
  parameter int WAKE_CYCLES = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_tick_i,
  input  logic slow_tick_i,
  input  logic cmd_n_i,
  input  logic mode_i,
  input  logic rst_req_i,
  input  logic card_present_i,
  input  logic ovc_i,
  input  logic ovt_i,
  input  logic sup_drop_i,
  output logic pump_en_o,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic rst_o,
  output logic irq_n_o
);
  localparam int HT_LAST = (ACT_RST_HT > DEA_PUMP_HT) ? ACT_RST_HT : DEA_PUMP_HT;
  localparam int HT_W    = $clog2(HT_LAST + 2);
  localparam int WK_W    = $clog2(WAKE_CYCLES + 2);

  seq_state_e      state_q, state_d;
  logic [HT_W-1:0] ht_step;
  logic [WK_W-1:0] wk_step;
  logic            ht_clr, wk_clr;
  logic            any_fault, fault_hit, fault_q, fault_d;
  logic            at_vcc_on, at_io_on, at_rst_on;
  logic            at_clk_off, at_io_off, at_vcc_off, at_pump_off, wake_done;
  logic            in_act, in_deact;
  logic            pump_d, vcc_d, io_d, clk_d, rst_d;

  card_seq_timer #(.WIDTH(HT_W)) u_half_timer (
    .clk_i, .rst_ni, .clr_i(ht_clr), .tick_i(half_tick_i), .step_o(ht_step)
  );

  card_seq_timer #(.WIDTH(WK_W)) u_wake_timer (
    .clk_i, .rst_ni, .clr_i(wk_clr), .tick_i(slow_tick_i), .step_o(wk_step)
  );

  card_seq_fault u_fault (
    .clk_i, .rst_ni,
    .ovc_i, .ovt_i, .present_i(card_present_i), .sup_drop_i,
    .raise_i(fault_hit),
    .clear_i(state_q == ST_FAULT && state_d == ST_IDLE),
    .any_o(any_fault), .irq_n_o
  );

  assign at_vcc_on   = half_tick_i && ht_step == HT_W'(ACT_VCC_HT);
  assign at_io_on    = half_tick_i && ht_step == HT_W'(ACT_IO_HT);
  assign at_rst_on   = half_tick_i && ht_step == HT_W'(ACT_RST_HT);
  assign at_clk_off  = half_tick_i && ht_step == HT_W'(DEA_CLK_HT);
  assign at_io_off   = half_tick_i && ht_step == HT_W'(DEA_IO_HT);
  assign at_vcc_off  = half_tick_i && ht_step == HT_W'(DEA_VCC_HT);
  assign at_pump_off = half_tick_i && ht_step == HT_W'(DEA_PUMP_HT);
  assign wake_done   = slow_tick_i && wk_step == WK_W'(WAKE_CYCLES);

  always_comb begin
    state_d   = state_q;
    fault_hit = 1'b0;
    unique case (state_q)
      ST_OFF:   if (!sup_drop_i) state_d = ST_IDLE;
      ST_IDLE: begin
        if (sup_drop_i)                     state_d = ST_OFF;
        else if (!mode_i)                   state_d = ST_SLEEP;
        else if (!cmd_n_i && !any_fault)    state_d = ST_ACT;
      end
      ST_SLEEP: if (mode_i && wake_done) state_d = ST_IDLE;
      ST_ACT, ST_ON: begin
        if (any_fault) begin
          state_d   = ST_DEACT;
          fault_hit = 1'b1;
        end else if (cmd_n_i || !mode_i) begin
          state_d = ST_DEACT;
        end else if (state_q == ST_ACT && at_rst_on) begin
          state_d = ST_ON;
        end
      end
      ST_DEACT: begin
        fault_hit = any_fault;  // recorded, schedule not restarted
        if (at_pump_off) begin
          if (fault_q || any_fault) state_d = ST_FAULT;
          else if (!mode_i)         state_d = ST_SLEEP;
          else                      state_d = ST_IDLE;
        end
      end
      ST_FAULT: if (cmd_n_i && !any_fault) state_d = ST_IDLE;
      default:  state_d = ST_OFF;
    endcase
  end

  assign ht_clr  = (state_d != state_q) && (state_d == ST_ACT || state_d == ST_DEACT);
  assign wk_clr  = (state_q != ST_SLEEP) || !mode_i;
  assign fault_d = (state_d == ST_DEACT) && (fault_q || fault_hit);
  assign in_act   = (state_q == ST_ACT);
  assign in_deact = (state_q == ST_DEACT);

  always_comb begin
    pump_d = 1'b0;
    vcc_d  = 1'b0;
    io_d   = 1'b0;
    clk_d  = 1'b0;
    rst_d  = 1'b0;
    unique case (state_d)
      ST_ACT: begin
        pump_d = 1'b1;
        vcc_d  = vcc_en_o | (in_act & at_vcc_on);
        io_d   = io_en_o  | (in_act & at_io_on);
        clk_d  = clk_en_o | (in_act & io_en_o & rst_req_i);
      end
      ST_ON: begin
        pump_d = 1'b1;
        vcc_d  = 1'b1;
        io_d   = 1'b1;
        clk_d  = clk_en_o;
        rst_d  = ~rst_req_i;
      end
      ST_DEACT: begin
        pump_d = pump_en_o;
        vcc_d  = vcc_en_o & ~(in_deact & at_vcc_off);
        io_d   = io_en_o  & ~(in_deact & at_io_off);
        clk_d  = clk_en_o & ~(in_deact & at_clk_off);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      fault_q   <= 1'b0;
      pump_en_o <= 1'b0;
      vcc_en_o  <= 1'b0;
      io_en_o   <= 1'b0;
      clk_en_o  <= 1'b0;
      rst_o     <= 1'b0;
    end else begin
      state_q   <= state_d;
      fault_q   <= fault_d;
      pump_en_o <= pump_d;
      vcc_en_o  <= vcc_d;
      io_en_o   <= io_d;
      clk_en_o  <= clk_d;
      rst_o     <= rst_d;
    end
  end

  p_vcc_under_pump_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_en_o |-> pump_en_o);
  p_io_under_vcc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o);
  p_clk_under_io_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> io_en_o);
  p_clk_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON) |=> (state_q != ST_ON || $stable(clk_en_o)));
  p_rst_needs_io_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> io_en_o);
  p_sleep_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !mode_i) |=> state_q != ST_ACT);
  p_fault_parks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && state_q == ST_DEACT && state_d != ST_DEACT) |=> state_q == ST_FAULT);
endmodule

// File: tb/card_pwr_seq_tb.sv
module card_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0, slow_tick = 1'b0;
  logic cmd_n = 1'b1, mode = 1'b1, rst_req = 1'b0, present = 1'b1;
  logic ovc = 1'b0, ovt = 1'b0, sup_drop = 1'b1;
  logic pump, vcc, io, cclk, crst, irq_n;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  card_pwr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .half_tick_i(half_tick), .slow_tick_i(slow_tick),
    .cmd_n_i(cmd_n), .mode_i(mode), .rst_req_i(rst_req), .card_present_i(present),
    .ovc_i(ovc), .ovt_i(ovt), .sup_drop_i(sup_drop),
    .pump_en_o(pump), .vcc_en_o(vcc), .io_en_o(io), .clk_en_o(cclk),
    .rst_o(crst), .irq_n_o(irq_n)
  );

  // expected vector order: {pump, vcc, io, clk, rst, irq_n}
  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {pump, vcc, io, cclk, crst, irq_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b, expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      half_tick = 1'b1;
      step();
      half_tick = 1'b0;
    end
  endtask

  task automatic stick(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1;
      step();
      slow_tick = 1'b0;
    end
  endtask

  task automatic take_down();
    cmd_n = 1'b1;
    step();
    tick(10);
    step();
  endtask

  task automatic t_reset_poweroff();
    chk("R1 reset", 6'b000001);
    cmd_n = 1'b0;
    step(); step();
    chk("R1 supply drop holds power-off", 6'b000001);
    sup_drop = 1'b0;
    step();
    chk("R1 power-off to idle", 6'b000001);
    step();
    chk("R2 activation after supply good", 6'b100001);
    take_down();
  endtask

  task automatic t_activation();
    cmd_n = 1'b0;
    step();
    chk("R2 converter on entry", 6'b100001);
    tick(2);
    chk("R3 before supply step", 6'b100001);
    tick(1);
    chk("R3 supply at 3rd half-tick", 6'b110001);
    tick(4);
    rst_req = 1'b1;
    step();
    chk("R4 request before io ignored", 6'b110001);
    tick(1);
    chk("R3 io at 8th half-tick", 6'b111001);
    step();
    chk("R4 clock starts in window", 6'b111101);
    tick(5);
    chk("R3 reset path not yet", 6'b111101);
    tick(1);
    chk("R5 reset follows request high", 6'b111101);
    rst_req = 1'b0;
    step();
    chk("R5 reset released", 6'b111111);
    rst_req = 1'b1;
    step();
    chk("R5 R4 reset again, clock kept", 6'b111101);
    rst_req = 1'b0;
    step();
  endtask

  task automatic t_deactivation();
    cmd_n = 1'b1;
    step();
    chk("R6 reset drops at entry", 6'b111101);
    tick(1);
    chk("R6 clock stops", 6'b111001);
    tick(1);
    chk("R6 io off", 6'b110001);
    tick(1);
    chk("R6 supply off", 6'b100001);
    tick(6);
    chk("R6 converter held", 6'b100001);
    tick(1);
    chk("R6 converter off", 6'b000001);
    cmd_n = 1'b0;
    step();
    chk("R6 idle accepts new session", 6'b100001);
    take_down();
  endtask

  task automatic t_no_clock_request();
    cmd_n = 1'b0;
    step();
    tick(14);
    chk("R4 no request no clock", 6'b111011);
    rst_req = 1'b1;
    step();
    chk("R4 request after window ignored", 6'b111001);
    rst_req = 1'b0;
    step();
  endtask

  task automatic t_fault_ovc();
    ovc = 1'b1;
    step();
    chk("R7 overcurrent interrupt", 6'b111000);
    ovc = 1'b0;
    tick(9);
    chk("R7 emergency schedule", 6'b100000);
    tick(1);
    chk("R7 converter off", 6'b000000);
    step();
    chk("R9 fault state blocks", 6'b000000);
    cmd_n = 1'b1;
    step();
    chk("R9 interrupt released", 6'b000001);
    cmd_n = 1'b0;
    step();
    chk("R9 session after release", 6'b100001);
  endtask

  task automatic t_fault_supply();
    tick(14);
    chk("R3 active again", 6'b111011);
    sup_drop = 1'b1;
    step();
    chk("R7 supply drop no interrupt", 6'b111001);
    tick(10);
    chk("R7 supply drop take-down", 6'b000001);
    sup_drop = 1'b0;
    step();
    chk("R9 no activation in fault", 6'b000001);
    cmd_n = 1'b1;
    step();
    cmd_n = 1'b0;
    step();
    chk("R9 activation after exit", 6'b100001);
  endtask

  task automatic t_fault_in_deact();
    tick(14);
    cmd_n = 1'b1;
    step();
    tick(4);
    chk("R6 mid take-down", 6'b100001);
    ovt = 1'b1;
    step();
    chk("R8 late fault interrupt", 6'b100000);
    ovt = 1'b0;
    tick(5);
    chk("R8 schedule not restarted", 6'b100000);
    tick(1);
    chk("R8 converter off at 10th", 6'b000000);
    step();
    chk("R8 R9 fault exit to idle", 6'b000001);
  endtask

  task automatic t_simultaneous();
    cmd_n = 1'b0;
    step();
    tick(14);
    cmd_n = 1'b1;
    present = 1'b0;
    step();
    chk("R7 removal with release", 6'b111000);
    present = 1'b1;
    tick(10);
    chk("R7 single take-down", 6'b000000);
    step();
    chk("R9 exit with command high", 6'b000001);
  endtask

  task automatic t_idle_block();
    present = 1'b0;
    cmd_n = 1'b0;
    step(); step();
    chk("R9 absent card blocks", 6'b000001);
    present = 1'b1;
    step();
    chk("R9 activation when clear", 6'b100001);
    take_down();
  endtask

  task automatic t_sleep();
    mode = 1'b0;
    step();
    cmd_n = 1'b0;
    step();
    chk("R10 no activation asleep", 6'b000001);
    mode = 1'b1;
    stick(50);
    mode = 1'b0;
    step();
    mode = 1'b1;
    stick(95);
    chk("R11 count restarted", 6'b000001);
    stick(1);
    chk("R11 idle on last pulse", 6'b000001);
    step();
    chk("R11 activation after wake", 6'b100001);
    tick(14);
    mode = 1'b0;
    step();
    chk("R10 mode low takes down", 6'b111001);
    tick(10);
    chk("R10 down into low-power", 6'b000001);
    mode = 1'b1;
    stick(95);
    chk("R10 R11 still asleep", 6'b000001);
    stick(1);
    step();
    chk("R11 wake from mode take-down", 6'b100001);
    take_down();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_poweroff();
    t_activation();
    t_deactivation();
    t_no_clock_request();
    t_fault_ovc();
    t_fault_supply();
    t_fault_in_deact();
    t_simultaneous();
    t_idle_block();
    t_sleep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: outputs stalled, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule